// File: doc/BRIEF.md
# Four-Channel Input Capture Unit

This block timestamps events on four external pins. A free-running 16-bit count arrives from a timer elsewhere on the chip. When a channel's pin shows an edge of the kind its edge-select field asks for, the channel stores the count of that cycle in its capture register and raises a sticky capture flag. Later qualifying edges overwrite the stored count. Each flag, gated by its own enable, drives an interrupt request line. Software lowers the flag by writing 0 to it.

Channels 2 and 3 also keep an edge-indicator bit. It shows whether the most recent qualifying edge was rising or falling. The bit follows every qualifying edge, including edges that arrive while an earlier capture is still waiting for service. Channels 0 and 1 have no such bit, and they report 0 in that position.

Each channel has a two-state controller. It sits in `CH_IDLE` while its flag is low and in `CH_PENDING` while the flag is high. Its transitions are:
- *arm*: `CH_IDLE` to `CH_PENDING` on a qualifying edge.
- *recapture*: `CH_PENDING` to `CH_PENDING` on a further qualifying edge.
- *service*: `CH_PENDING` to `CH_IDLE` on a software clear with no edge in the same cycle.
- *hold*: stay in the current state when nothing happens.

Top module: `ic_capture_unit`

## Requirements
- R1: After reset all capture flags, capture registers, edge-indicator bits and interrupt requests are 0.
- R2: With edge select 2'b01 (rising) a channel captures on a 0-to-1 pin change and ignores a 1-to-0 change.
- R3: With edge select 2'b10 (falling) a channel captures on a 1-to-0 pin change and ignores a 0-to-1 change.
- R4: With edge select 2'b11 (both) a channel captures on either pin change.
- R5: With edge select 2'b00 a channel never captures: its flag and capture register are unchanged by pin activity.
- R6: A pin change is recognised after a two-flop synchroniser. The capture register and flag update on the third rising clock edge after the pin changes, and the register takes the timer value present at that edge. A later qualifying edge overwrites the register.
- R7: A capture flag stays 1 until software writes 0 to it (flag_wr bit 1 with flag_wdata bit 0). Writing 1 has no effect.
- R8: If a clear write and a qualifying edge fall in the same cycle, the flag stays 1 and the register takes the new count.
- R9: irq[i] is 1 exactly when cap_flag[i] and irq_en[i] are both 1.
- R10: On channels 2 and 3 the edge-indicator bit is 1 after a rising qualifying edge and 0 after a falling one. It updates on every qualifying edge, even while the flag is already set.
- R11: Edge-indicator bits 0 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Free-running count to be captured |
| cap_pin | input | 4 | Asynchronous capture pins, bit i for channel i |
| edge_sel | input | 8 | Edge select, bits [2i+1:2i] for channel i (00 off, 01 rise, 10 fall, 11 both) |
| irq_en | input | 4 | Interrupt enable for each channel |
| flag_wr | input | 4 | Flag write strobe for each channel |
| flag_wdata | input | 4 | Flag write data; 0 clears, 1 has no effect |
| cap_flag | output | 4 | Sticky capture flags |
| edge_ind | output | 4 | Last-edge polarity (1 rising); bits 0 and 1 tied to 0 |
| cap_value | output | 64 | Capture registers, bits [16i+15:16i] for channel i |
| irq | output | 4 | Interrupt requests |

## Verification
The functions that can land on the same clock edge are a software clear of a flag and the recognition of a new qualifying edge on that channel. The bench provokes the overlap by changing a pin and then raising the clear strobe for exactly the cycle that ends on the third rising edge. That is the edge on which the synchronised change is recognised. The result is judged by the flag still reading 1 and the capture register holding the count driven for that edge. A plain clear is then checked to lower the flag. A second overlap, an edge arriving while a flag is pending, is judged by the edge-indicator bit turning over while the flag stays set.

// File: rtl/ic_cap_pkg.sv
package ic_cap_pkg;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/ic_pin_sync.sv
module ic_pin_sync
    import ic_cap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    output edge_evt_t evt_o
);

    localparam int MSB = STAGES - 1;

    logic [MSB:0] chain_q;
    logic         prev_q;

    // Synchroniser chain; prev_q holds the sample of one cycle earlier.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[MSB-1:0], pin_i};
            prev_q  <= chain_q[MSB];
        end
    end

    always_comb begin
        evt_o.rise = chain_q[MSB] & ~prev_q;
        evt_o.fall = ~chain_q[MSB] & prev_q;
    end

endmodule

// File: rtl/ic_edge_qual.sv
module ic_edge_qual
    import ic_cap_pkg::*;
(
    input  edge_sel_e sel_i,
    input  edge_evt_t evt_i,
    output logic      hit_o,
    output logic      hit_rise_o
);

    always_comb begin
        hit_o = 1'b0;
        unique case (sel_i)
            SEL_OFF:  hit_o = 1'b0;
            SEL_RISE: hit_o = evt_i.rise;
            SEL_FALL: hit_o = evt_i.fall;
            SEL_BOTH: hit_o = evt_i.rise | evt_i.fall;
        endcase
        hit_rise_o = evt_i.rise;
    end

endmodule

// File: rtl/ic_channel.sv
module ic_channel
    import ic_cap_pkg::*;
#(
    parameter int TW      = 16,
    parameter bit HAS_IND = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  edge_evt_t     evt_i,
    input  edge_sel_e     sel_i,
    input  logic          clr_i,
    input  logic [TW-1:0] timer_i,
    output logic          flag_o,
    output logic [TW-1:0] cap_o,
    output logic          ind_o
);

    ch_state_e     state_q, state_d;
    logic          hit, hit_rise;
    logic [TW-1:0] cap_q;
    logic          ind_q;

    ic_edge_qual u_qual (
        .sel_i      (sel_i),
        .evt_i      (evt_i),
        .hit_o      (hit),
        .hit_rise_o (hit_rise)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Next state: arm, recapture, service, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (hit) state_d = CH_PENDING;
            end
            CH_PENDING: begin
                if (hit)        state_d = CH_PENDING;
                else if (clr_i) state_d = CH_IDLE;
            end
        endcase
    end

    // Capture register and polarity record, both loaded on a qualifying edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            ind_q <= 1'b0;
        end else if (hit) begin
            cap_q <= timer_i;
            ind_q <= hit_rise;
        end
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == CH_PENDING);
        cap_o  = cap_q;
        ind_o  = HAS_IND ? ind_q : 1'b0;
    end

endmodule

// File: rtl/ic_capture_unit.sv
module ic_capture_unit
    import ic_cap_pkg::*;
#(
    parameter int                NUM_CH   = 4,
    parameter int                TW       = 16,
    parameter int                SYNC_LEN = 2,
    parameter logic [NUM_CH-1:0] IND_MASK = 4'b1100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        timer_val,
    input  logic [NUM_CH-1:0]    cap_pin,
    input  logic [2*NUM_CH-1:0]  edge_sel,
    input  logic [NUM_CH-1:0]    irq_en,
    input  logic [NUM_CH-1:0]    flag_wr,
    input  logic [NUM_CH-1:0]    flag_wdata,
    output logic [NUM_CH-1:0]    cap_flag,
    output logic [NUM_CH-1:0]    edge_ind,
    output logic [NUM_CH*TW-1:0] cap_value,
    output logic [NUM_CH-1:0]    irq
);

    localparam int SELW = 2;

    logic [NUM_CH-1:0] clr_req;

    assign clr_req = flag_wr & ~flag_wdata;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        edge_evt_t evt;

        ic_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (cap_pin[i]),
            .evt_o (evt)
        );

        ic_channel #(.TW(TW), .HAS_IND(IND_MASK[i])) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt),
            .sel_i   (edge_sel_e'(edge_sel[SELW*i +: SELW])),
            .clr_i   (clr_req[i]),
            .timer_i (timer_val),
            .flag_o  (cap_flag[i]),
            .cap_o   (cap_value[TW*i +: TW]),
            .ind_o   (edge_ind[i])
        );
    end

    assign irq = cap_flag & irq_en;

endmodule

// File: rtl/ic_capture_unit_chk.sv
module ic_capture_unit_chk #(
    parameter int                NUM_CH   = 4,
    parameter int                TW       = 16,
    parameter logic [NUM_CH-1:0] IND_MASK = 4'b1100
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TW-1:0]        timer_val,
    input logic [2*NUM_CH-1:0]  edge_sel,
    input logic [NUM_CH-1:0]    irq_en,
    input logic [NUM_CH-1:0]    flag_wr,
    input logic [NUM_CH-1:0]    flag_wdata,
    input logic [NUM_CH-1:0]    cap_flag,
    input logic [NUM_CH-1:0]    edge_ind,
    input logic [NUM_CH*TW-1:0] cap_value,
    input logic [NUM_CH-1:0]    irq
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (cap_flag[i] && irq_en[i]));

        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_flag[i] && !(flag_wr[i] && !flag_wdata[i])) |=> cap_flag[i]);

        p_off_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[2*i +: 2] == 2'b00) |=> $stable(cap_value[TW*i +: TW]));

        p_off_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel[2*i +: 2] == 2'b00 && !cap_flag[i]) |=> !cap_flag[i]);

        p_capture_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cap_flag[i]) |-> (cap_value[TW*i +: TW] == $past(timer_val)));

        if (!IND_MASK[i]) begin : g_noind
            p_no_indicator_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !edge_ind[i]);
        end
    end

endmodule

bind ic_capture_unit ic_capture_unit_chk #(
    .NUM_CH   (NUM_CH),
    .TW       (TW),
    .IND_MASK (IND_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_val  (timer_val),
    .edge_sel   (edge_sel),
    .irq_en     (irq_en),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .cap_flag   (cap_flag),
    .edge_ind   (edge_ind),
    .cap_value  (cap_value),
    .irq        (irq)
);

// File: tb/tb_ic_capture_unit.sv
module tb_ic_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic [3:0]  pin = '0;
    logic [7:0]  edge_sel = '0;
    logic [3:0]  irq_en = '0;
    logic [3:0]  flag_wr = '0;
    logic [3:0]  flag_wdata = '0;
    logic [3:0]  cap_flag, edge_ind, irq;
    logic [63:0] cap_value;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    ic_capture_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_val  (timer_val),
        .cap_pin    (pin),
        .edge_sel   (edge_sel),
        .irq_en     (irq_en),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .cap_flag   (cap_flag),
        .edge_ind   (edge_ind),
        .cap_value  (cap_value),
        .irq        (irq)
    );

    // Vector: {channel[1:0], select[1:0], new pin level, capture expected}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        {2'd0, 2'b01, 1'b1, 1'b1},
        {2'd0, 2'b01, 1'b0, 1'b0},
        {2'd1, 2'b10, 1'b1, 1'b0},
        {2'd1, 2'b10, 1'b0, 1'b1},
        {2'd2, 2'b11, 1'b1, 1'b1},
        {2'd2, 2'b11, 1'b0, 1'b1},
        {2'd3, 2'b00, 1'b1, 1'b0},
        {2'd3, 2'b11, 1'b0, 1'b1},
        {2'd3, 2'b01, 1'b1, 1'b1},
        {2'd2, 2'b10, 1'b1, 1'b0},
        {2'd2, 2'b10, 1'b0, 1'b1},
        {2'd0, 2'b11, 1'b1, 1'b1}
    };

    logic [15:0] exp_cap [4];
    logic        exp_ind [4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic clear_all();
        @(negedge clk);
        flag_wr = 4'hF; flag_wdata = 4'h0;
        @(negedge clk);
        flag_wr = 4'h0;
    endtask

    // Change a pin and step to the negedge after the third rising edge
    task automatic toggle_and_wait(input int ch, input logic lvl, input logic [15:0] t);
        timer_val = t;
        pin[ch]   = lvl;
        repeat (3) @(negedge clk);
    endtask

    function automatic string sel_req(input logic [1:0] s);
        case (s)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            exp_cap[c] = '0;
            exp_ind[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flags", {28'd0, cap_flag}, 32'd0);
        check("R1 irq", {28'd0, irq}, 32'd0);
        check("R1 ind", {28'd0, edge_ind}, 32'd0);
        check("R1 cap lo", cap_value[31:0], 32'd0);
        check("R1 cap hi", cap_value[63:32], 32'd0);
        rst_n = 1'b1;
        irq_en = 4'hF;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int          ch;
            logic [1:0]  s;
            logic        lvl, hit;
            logic [15:0] t;
            ch  = int'(VEC[v][5:4]);
            s   = VEC[v][3:2];
            lvl = VEC[v][1];
            hit = VEC[v][0];
            t   = 16'hA000 + 16'(v) * 16'h0111;
            clear_all();
            edge_sel[2*ch +: 2] = s;
            toggle_and_wait(ch, lvl, t);
            if (hit) begin
                exp_cap[ch] = t;
                exp_ind[ch] = lvl;
            end
            check(sel_req(s), {31'd0, cap_flag[ch]}, {31'd0, hit});
            check("R6 value", {16'd0, cap_value[16*ch +: 16]}, {16'd0, exp_cap[ch]});
            check("R9 irq", {31'd0, irq[ch]}, {31'd0, hit});
            if (ch >= 2) check("R10 ind", {31'd0, edge_ind[ch]}, {31'd0, exp_ind[ch]});
            else         check("R11 ind", {31'd0, edge_ind[ch]}, 32'd0);
        end

        // R7 / R9: sticky flag, write-1 ignored, enable gating
        clear_all();
        edge_sel[3:2] = 2'b01;
        toggle_and_wait(1, 1'b1, 16'h1234);
        check("R2 rise ch1", {31'd0, cap_flag[1]}, 32'd1);
        repeat (6) @(negedge clk);
        check("R7 sticky", {31'd0, cap_flag[1]}, 32'd1);
        flag_wr = 4'b0010; flag_wdata = 4'b0010;
        @(negedge clk);
        flag_wr = 4'h0;
        check("R7 write one", {31'd0, cap_flag[1]}, 32'd1);
        irq_en = 4'b1101;
        @(negedge clk);
        check("R9 masked", {31'd0, irq[1]}, 32'd0);
        irq_en = 4'hF;
        @(negedge clk);
        check("R9 unmasked", {31'd0, irq[1]}, 32'd1);
        flag_wr = 4'b0010; flag_wdata = 4'b0000;
        @(negedge clk);
        flag_wr = 4'h0;
        check("R7 clear", {31'd0, cap_flag[1]}, 32'd0);
        check("R9 after clear", {31'd0, irq[1]}, 32'd0);

        // R8: clear lands on the capture edge
        clear_all();
        edge_sel[1:0] = 2'b11;
        toggle_and_wait(0, 1'b0, 16'h2222);
        check("R4 fall ch0", {31'd0, cap_flag[0]}, 32'd1);
        timer_val = 16'h3333;
        pin[0]    = 1'b1;
        repeat (2) @(negedge clk);
        flag_wr = 4'b0001; flag_wdata = 4'b0000;
        @(negedge clk);
        flag_wr = 4'h0;
        check("R8 flag kept", {31'd0, cap_flag[0]}, 32'd1);
        check("R8 new count", {16'd0, cap_value[15:0]}, 32'h3333);
        check("R11 ch0", {31'd0, edge_ind[0]}, 32'd0);
        flag_wr = 4'b0001;
        @(negedge clk);
        flag_wr = 4'h0;
        check("R7 plain clear", {31'd0, cap_flag[0]}, 32'd0);

        // R10 / R6: indicator follows edges while pending; overwrite
        clear_all();
        edge_sel[7:6] = 2'b11;
        toggle_and_wait(3, 1'b0, 16'h4444);
        check("R10 falling", {31'd0, edge_ind[3]}, 32'd0);
        toggle_and_wait(3, 1'b1, 16'h5555);
        check("R10 pending flag", {31'd0, cap_flag[3]}, 32'd1);
        check("R10 rising while pending", {31'd0, edge_ind[3]}, 32'd1);
        check("R6 overwrite", {16'd0, cap_value[63:48]}, 32'h5555);

        // R5: pin activity with select off
        edge_sel[7:6] = 2'b00;
        clear_all();
        toggle_and_wait(3, 1'b0, 16'h6666);
        check("R5 flag", {31'd0, cap_flag[3]}, 32'd0);
        check("R5 value", {16'd0, cap_value[63:48]}, 32'h5555);
        check("R5 ind", {31'd0, edge_ind[3]}, 32'd1);

        finish_run();
    end

endmodule